// File: doc/BRIEF.md
# Addressed Serial Load Port for a Four-Channel Converter Bank

This block receives 16-bit serial words and uses them to fill a bank of four 12-bit channel registers, meant to feed a four-channel digital-to-analog converter. A frame opens when the active-low frame-sync input falls. Bits are captured on falling edges of the serial clock. Each word carries a 12-bit code, a 2-bit device address and a 2-bit channel select. A word whose address field equals the two strapped address pins writes its code into the input latch of the selected channel. All other words are dropped.

Storage is double buffered. Four output latches drive the converter. They change only when the active-low clear input forces them to zero, or when the active-low load input copies all four input latches across in one step. The tail of the shift register leaves on a serial output, so several devices can share one data line in a daisy chain. All serial and strobe inputs are asynchronous. They are brought into the system clock through synchronisers.

Top module: `dsl_top`

## Requirements
- R1: A word is sent most significant bit first. Bits [15:4] hold the code, bits [3:2] the device address and bits [1:0] the channel select.
- R2: On the sixteenth falling serial-clock edge of a frame, the code is written to the selected input latch, provided bits [3:2] equal the address pins.
- R3: Channel select values 0, 1, 2 and 3 write channels 0 to 3 respectively. Channel n is bits [12n+11:12n] of `dac_code_o`. At most one input latch is written per word.
- R4: A word whose address field differs from the address pins writes no input latch.
- R5: `sdata_o` is bit 15 of the shift register, so after 16 edges it shows the first bit of the word. This holds whether or not the address matched.
- R6: While clear is low, all four output latches read zero.
- R7: While load is low and clear is high, all four output latches take the input latch values together.
- R8: When clear and load are low together, clear wins and the outputs read zero.
- R9: Raising frame sync before the sixteenth edge discards the partial word. The next frame counts from one again.
- R10: Falling edges after the sixteenth in the same frame keep shifting but write no latch.
- R11: After reset, all outputs and `sdata_o` are zero.
- R12: While clear and load are both high, the output latches hold, even when input latches are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| fsync_n_i | input | 1 | Active-low frame sync, level sensitive |
| sdata_i | input | 1 | Serial data in |
| clr_n_i | input | 1 | Active-low clear of the output latches |
| ld_n_i | input | 1 | Active-low load from input latches to output latches |
| dev_addr_i | input | 2 | Strapped device address |
| sdata_o | output | 1 | Shift-register tail for daisy chaining |
| dac_code_o | output | 48 | Four 12-bit output latches, channel 0 in the low bits |

## Verification
Each input passes two synchroniser flops. A clear or load change therefore reaches `dac_code_o` on the third system clock edge. A serial falling edge updates `sdata_o` on the third edge. The input latch is written on the fourth edge, so the output follows on the fifth edge while load is held low. The bench freezes stimulus after every action and samples only after eight clock cycles, on a falling clock edge. This keeps all of those latencies inside the window. The serial clock half-period is four system cycles, so every serial edge is seen once.

// File: rtl/dsl_pkg.sv
package dsl_pkg;
    parameter int CODE_W  = 12;
    parameter int SEL_W   = 2;
    parameter int ADDR_W  = 2;
    parameter int NUM_CH  = 1 << SEL_W;
    parameter int WORD_W  = CODE_W + ADDR_W + SEL_W;
    parameter int ADDR_LSB = SEL_W;
    parameter int CNT_W   = $clog2(WORD_W + 1);
    parameter int SYNC_STAGES = 2;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              sclk_prev;
        logic              wr;
    } rx_state_t;

    typedef struct packed {
        code_t [NUM_CH-1:0] inl;
        code_t [NUM_CH-1:0] outl;
    } bank_state_t;
endpackage

// File: rtl/dsl_sync.sv
module dsl_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {STAGES{RST_VAL}};
        else        st_q <= st_d;
    end

    assign sync_o = st_q[STAGES-1];
endmodule

// File: rtl/dsl_frame_rx.sv
module dsl_frame_rx
    import dsl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              fsync_n_s,
    input  logic              sdata_s,
    input  logic [ADDR_W-1:0] dev_addr,
    output logic              wr_o,
    output logic [SEL_W-1:0]  wr_sel_o,
    output code_t             wr_code_o,
    output logic [ADDR_W-1:0] addr_field_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              sdout_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    rx_state_t st_d, st_q;
    logic              fall;
    logic [WORD_W-1:0] shifted;

    always_comb begin
        st_d           = st_q;
        st_d.wr        = 1'b0;
        st_d.sclk_prev = sclk_s;
        fall           = st_q.sclk_prev & ~sclk_s;
        shifted        = {st_q.shreg[WORD_W-2:0], sdata_s};
        if (fsync_n_s) begin
            st_d.cnt = '0;
        end else if (fall) begin
            st_d.shreg = shifted;
            if (st_q.cnt != FULL) st_d.cnt = st_q.cnt + 1'b1;
            if ((st_q.cnt == LAST) &&
                (shifted[ADDR_LSB +: ADDR_W] == dev_addr)) begin
                st_d.wr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_o         = st_q.wr;
    assign wr_sel_o     = st_q.shreg[SEL_W-1:0];
    assign wr_code_o    = st_q.shreg[WORD_W-1 -: CODE_W];
    assign addr_field_o = st_q.shreg[ADDR_LSB +: ADDR_W];
    assign cnt_o        = st_q.cnt;
    assign sdout_o      = st_q.shreg[WORD_W-1];
endmodule

// File: rtl/dsl_latch_bank.sv
module dsl_latch_bank
    import dsl_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_i,
    input  logic [SEL_W-1:0]         wr_sel_i,
    input  code_t                    wr_code_i,
    input  logic                     clr_n_s,
    input  logic                     ld_n_s,
    output logic [NUM_CH-1:0]        wen_o,
    output logic [NUM_CH*CODE_W-1:0] in_flat_o,
    output logic [NUM_CH*CODE_W-1:0] out_flat_o
);
    bank_state_t st_d, st_q;
    logic [NUM_CH-1:0] wen;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign wen[g] = wr_i && (wr_sel_i == SEL_W'(g));
        assign in_flat_o[g*CODE_W +: CODE_W]  = st_q.inl[g];
        assign out_flat_o[g*CODE_W +: CODE_W] = st_q.outl[g];
    end

    always_comb begin
        st_d = st_q;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (wen[ch]) st_d.inl[ch] = wr_code_i;
        end
        if (!clr_n_s)     st_d.outl = '0;
        else if (!ld_n_s) st_d.outl = st_q.inl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wen_o = wen;
endmodule

// File: rtl/dsl_top.sv
module dsl_top
    import dsl_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sclk_i,
    input  logic                     fsync_n_i,
    input  logic                     sdata_i,
    input  logic                     clr_n_i,
    input  logic                     ld_n_i,
    input  logic [ADDR_W-1:0]        dev_addr_i,
    output logic                     sdata_o,
    output logic [NUM_CH*CODE_W-1:0] dac_code_o
);
    logic [4:0] raw, synced;
    logic sclk_s, fsync_n_s, sdata_s, clr_n_s, ld_n_s;

    logic              wr;
    logic [SEL_W-1:0]  wr_sel;
    code_t             wr_code;
    logic [ADDR_W-1:0] addr_field;
    logic [CNT_W-1:0]  frame_cnt;
    logic [NUM_CH-1:0] wen;
    logic [NUM_CH*CODE_W-1:0] in_flat;

    assign raw = {clr_n_i, ld_n_i, fsync_n_i, sdata_i, sclk_i};

    dsl_sync #(
        .WIDTH  (5),
        .STAGES (SYNC_STAGES),
        .RST_VAL(5'b11100)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw),
        .sync_o (synced)
    );

    assign {clr_n_s, ld_n_s, fsync_n_s, sdata_s, sclk_s} = synced;

    dsl_frame_rx rx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_s      (sclk_s),
        .fsync_n_s   (fsync_n_s),
        .sdata_s     (sdata_s),
        .dev_addr    (dev_addr_i),
        .wr_o        (wr),
        .wr_sel_o    (wr_sel),
        .wr_code_o   (wr_code),
        .addr_field_o(addr_field),
        .cnt_o       (frame_cnt),
        .sdout_o     (sdata_o)
    );

    dsl_latch_bank bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr),
        .wr_sel_i  (wr_sel),
        .wr_code_i (wr_code),
        .clr_n_s   (clr_n_s),
        .ld_n_s    (ld_n_s),
        .wen_o     (wen),
        .in_flat_o (in_flat),
        .out_flat_o(dac_code_o)
    );
endmodule

// File: rtl/dsl_checker.sv
module dsl_checker
    import dsl_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     clr_n_s,
    input logic                     ld_n_s,
    input logic                     wr,
    input logic [CNT_W-1:0]         frame_cnt,
    input logic [ADDR_W-1:0]        addr_field,
    input logic [ADDR_W-1:0]        dev_addr_i,
    input logic [NUM_CH-1:0]        wen,
    input logic [NUM_CH*CODE_W-1:0] in_flat,
    input logic [NUM_CH*CODE_W-1:0] dac_code_o
);
    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n_s |=> (dac_code_o == '0));

    assert_load_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n_s && !ld_n_s) |=> (dac_code_o == $past(in_flat)));

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n_s && !ld_n_s) |=> (dac_code_o == '0));

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n_s && ld_n_s) |=> $stable(dac_code_o));

    assert_write_on_16th_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> (frame_cnt == CNT_W'(WORD_W)));

    assert_addr_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> (addr_field == dev_addr_i));

    assert_one_channel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wen));

    assert_enable_needs_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wen != '0) |-> wr);
endmodule

bind dsl_top dsl_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n_s   (clr_n_s),
    .ld_n_s    (ld_n_s),
    .wr        (wr),
    .frame_cnt (frame_cnt),
    .addr_field(addr_field),
    .dev_addr_i(dev_addr_i),
    .wen       (wen),
    .in_flat   (in_flat),
    .dac_code_o(dac_code_o)
);

// File: tb/dsl_top_tb_top.sv
module dsl_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, fsync_n = 1'b1, sdata = 1'b0, clr_n = 1'b1, ld_n = 1'b1;
    logic [1:0]  dev_addr = 2'b10;
    logic        sdout;
    logic [47:0] dac;

    always #5 clk = ~clk;

    dsl_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk),
        .fsync_n_i (fsync_n),
        .sdata_i   (sdata),
        .clr_n_i   (clr_n),
        .ld_n_i    (ld_n),
        .dev_addr_i(dev_addr),
        .sdata_o   (sdout),
        .dac_code_o(dac)
    );

    typedef struct {
        int          kind;
        int          ch;
        logic [11:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    function automatic logic [15:0] mk(input logic [11:0] code,
                                       input logic [1:0] addr,
                                       input logic [1:0] ch);
        return {code, addr, ch};
    endfunction

    task automatic expect_ch(input int ch, input logic [11:0] v, input string tag);
        sb_item_t it;
        it.kind = 0; it.ch = ch; it.exp = v; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic expect_sdo(input logic v, input string tag);
        sb_item_t it;
        it.kind = 1; it.ch = 0; it.exp = {11'd0, v}; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic drain();
        wait (sb_q.size() == 0);
        @(negedge clk);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        sdata = b;
        sclk  = 1'b1;
        wait_clk(4);
        sclk  = 1'b0;
        wait_clk(4);
    endtask

    task automatic shift_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic send_frame(input logic [15:0] w);
        fsync_n = 1'b0;
        wait_clk(4);
        shift_word(w);
        fsync_n = 1'b1;
        wait_clk(4);
    endtask

    task automatic pulse_load();
        ld_n = 1'b0;
        wait_clk(6);
        ld_n = 1'b1;
        wait_clk(4);
    endtask

    // monitor: samples each expected item eight cycles after it is queued
    initial begin
        forever begin
            sb_item_t it;
            logic [11:0] act;
            wait (sb_q.size() > 0);
            wait_clk(8);
            it = sb_q[0];
            act = (it.kind == 0) ? dac[it.ch*12 +: 12] : {11'd0, sdout};
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: kind %0d ch %0d actual %h expected %h",
                         it.tag, it.kind, it.ch, act, it.exp);
            end
            void'(sb_q.pop_front());
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);

        // R11: reset state
        for (int c = 0; c < 4; c++) expect_ch(c, 12'h000, "R11 reset");
        expect_sdo(1'b0, "R11 reset sdout");
        drain();

        // R1 R2 R12: matching write lands in input latch only
        send_frame(mk(12'hABC, 2'b10, 2'd0));
        expect_ch(0, 12'h000, "R12 hold after write");
        expect_sdo(1'b1, "R5 sdout after match");
        drain();
        pulse_load();
        expect_ch(0, 12'hABC, "R1 R2 R7 load ch0");
        drain();

        // R3: every channel
        send_frame(mk(12'h123, 2'b10, 2'd1));
        send_frame(mk(12'h456, 2'b10, 2'd2));
        send_frame(mk(12'hFED, 2'b10, 2'd3));
        pulse_load();
        expect_ch(0, 12'hABC, "R3 ch0");
        expect_ch(1, 12'h123, "R3 ch1");
        expect_ch(2, 12'h456, "R3 ch2");
        expect_ch(3, 12'hFED, "R3 ch3");
        drain();

        // R4 R5: wrong address, still forwarded
        send_frame(mk(12'h777, 2'b01, 2'd1));
        expect_sdo(1'b0, "R5 sdout after mismatch");
        drain();
        pulse_load();
        expect_ch(1, 12'h123, "R4 mismatch ignored");
        drain();

        // R9: aborted frame then full frame
        fsync_n = 1'b0;
        wait_clk(4);
        for (int i = 15; i >= 8; i--) shift_bit(mk(12'h999, 2'b10, 2'd2)[i]);
        fsync_n = 1'b1;
        wait_clk(6);
        send_frame(mk(12'h5A5, 2'b10, 2'd3));
        pulse_load();
        expect_ch(2, 12'h456, "R9 partial discarded");
        expect_ch(3, 12'h5A5, "R9 counter restarted");
        drain();

        // R10 R5: two words in one frame
        fsync_n = 1'b0;
        wait_clk(4);
        shift_word(mk(12'h321, 2'b10, 2'd0));
        expect_sdo(1'b0, "R5 sdout mid frame");
        drain();
        shift_word(mk(12'h8F0, 2'b10, 2'd1));
        expect_sdo(1'b1, "R5 R10 sdout after 32 edges");
        drain();
        fsync_n = 1'b1;
        wait_clk(4);
        pulse_load();
        expect_ch(0, 12'h321, "R10 first word written");
        expect_ch(1, 12'h123, "R10 extra edges no write");
        drain();

        // R6: clear, then reload from input latches
        clr_n = 1'b0;
        for (int c = 0; c < 4; c++) expect_ch(c, 12'h000, "R6 clear");
        drain();
        clr_n = 1'b1;
        wait_clk(4);
        pulse_load();
        expect_ch(3, 12'h5A5, "R6 R7 reload after clear");
        drain();

        // R8: clear and load together
        clr_n = 1'b0;
        ld_n  = 1'b0;
        expect_ch(0, 12'h000, "R8 clear wins ch0");
        expect_ch(3, 12'h000, "R8 clear wins ch3");
        drain();
        ld_n = 1'b1;
        wait_clk(4);
        clr_n = 1'b1;
        wait_clk(4);
        expect_ch(2, 12'h000, "R12 hold after release");
        drain();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule